// File: doc/BRIEF.md
# Ingress Local/Transit Packet Classifier

This block sits on the receive path of a line interface, right after link-layer extraction. Packets arrive as 128-bit beats with start and end flags, an empty-byte count on the last beat and a 2-bit class tag. The block captures the destination address from the leading beats and asks an external address-match engine whether that address belongs to the router. It then steers the packet to one of two streams. Packets addressed to the router go unchanged to a host-delivery stream that feeds the control processor. All other packets go to a fabric stream with a 128-bit internal routing header in front.

The header carries a class code, the packet's protocol byte and a 3-bit rack, 3-bit port and 3-bit interface number. The routing numbers are taken from configuration inputs at the first beat of each packet. While a lookup is outstanding the block holds the leading beats in a small FIFO and refuses further input, so packets never overtake each other. A packet that ends before its address is complete is discarded and counted. A packet whose lookup gets no answer within a bounded time is also discarded and counted.

Top module: `ingress_classifier`

## Requirements
- R1: Once the address beats of a packet have been accepted, exactly one single-cycle lookup request is issued. The request carries the class code (00 IPv4 unicast, 01 IPv4 multicast, 10 IPv6 unicast, 11 IPv6 multicast). For IPv4 the key holds packet bytes 16..19 in bits [31:0] with all other bits zero. For IPv6 the key holds bytes 24..39, byte 24 in bits [127:120]. Byte 0 of a beat is bits [127:120].
- R2: On a hit response the packet leaves on the host stream with every beat's data, start flag, end flag and empty count unchanged, and nothing appears on the fabric stream.
- R3: On a miss response the fabric stream first carries one header beat (start flag set, end flag clear, empty count 0) and then the packet beats with the start flag cleared. The header layout is: class in [127:124] as {00, class}, protocol in [123:116], rack in [115:113], port in [112:110], interface in [109:107], and zero in all other bits.
- R4: The rack, port and interface numbers in the header are the configuration values present when the packet's first beat is accepted. Later changes to the configuration do not affect that packet.
- R5: The protocol field is packet byte 9 for IPv4 classes and byte 6 for IPv6 classes.
- R6: Input ready stays low from the lookup request until the response or timeout, so beats of later packets are never accepted ahead of the current one.
- R7: If no response arrives within TIMEOUT_CYC cycles of the request, the whole packet is discarded on both streams and the drop count rises by one. The next packet is handled normally.
- R8: A packet whose end beat comes before its address is complete is discarded without a lookup and the drop count rises by one. IPv4 needs at least 2 beats and IPv6 at least 3 beats. A packet that ends exactly on its address beat is valid.
- R9: While an output is valid and not ready, its valid, data and flags hold steady.
- R10: During reset both outputs and the lookup request are low and the drop count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rack | input | 3 | Destination rack number for headers |
| cfg_port | input | 3 | Destination port number for headers |
| cfg_ifc | input | 3 | Destination interface number for headers |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 128 | Input beat, byte 0 in [127:120] |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_mty | input | 4 | Unused bytes in the last beat |
| in_ptype | input | 2 | Class code of the packet |
| lk_req_valid | output | 1 | Single-cycle lookup request |
| lk_key | output | 128 | Destination address key |
| lk_class | output | 2 | Class code of the key |
| lk_resp_valid | input | 1 | Lookup response strobe |
| lk_resp_hit | input | 1 | Address is local when high |
| host_valid | output | 1 | Host stream beat valid |
| host_ready | input | 1 | Host stream ready |
| host_data | output | 128 | Host stream data |
| host_sop | output | 1 | Host stream first beat |
| host_eop | output | 1 | Host stream last beat |
| host_mty | output | 4 | Host stream empty count |
| fab_valid | output | 1 | Fabric stream beat valid |
| fab_ready | input | 1 | Fabric stream ready |
| fab_data | output | 128 | Fabric stream data |
| fab_sop | output | 1 | Fabric stream first beat (header) |
| fab_eop | output | 1 | Fabric stream last beat |
| fab_mty | output | 4 | Fabric stream empty count |
| drop_count | output | 16 | Count of discarded packets |

## Verification
The bench sends packets of all four classes. Some end exactly on the address beat, some are shorter than that and one never gets a lookup answer. A design that counted address beats wrongly would either issue lookups for truncated packets or drop valid minimum-length ones. A design that read the wrong address or protocol bytes would produce a key or header that does not match. The configuration is changed one beat after every start beat, which exposes a header that samples the routing numbers too late. Random backpressure on both outputs and a checked quiet input during each lookup expose beats that are lost, repeated, reordered or accepted early. After a timeout, a following packet must pass normally, which shows that no stale state remains.

// File: rtl/icls_pkg.sv
package icls_pkg;
  localparam int DW      = 128;
  localparam int MTY_W   = 4;
  localparam int CLS_W   = 2;
  localparam int PROTO_W = 8;
  localparam int LOC_W   = 3;
  localparam int HDR_USED = 2 + CLS_W + PROTO_W + 3 * LOC_W;

  typedef struct packed {
    logic [DW-1:0]    data;
    logic             sop;
    logic             eop;
    logic [MTY_W-1:0] mty;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_LOOKUP,
    ST_WAIT,
    ST_HDR,
    ST_FWD,
    ST_DROP
  } st_e;

  function automatic logic [DW-1:0] build_hdr(
    input logic [CLS_W-1:0]   cls,
    input logic [PROTO_W-1:0] proto,
    input logic [LOC_W-1:0]   rack,
    input logic [LOC_W-1:0]   port,
    input logic [LOC_W-1:0]   ifc
  );
    return {2'b00, cls, proto, rack, port, ifc, {(DW - HDR_USED){1'b0}}};
  endfunction
endpackage

// File: rtl/icls_fifo.sv
module icls_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_nx, rd_q, rd_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
  endfunction

  always_comb begin
    wr_nx  = wr_q;
    rd_nx  = rd_q;
    cnt_nx = cnt_q;
    if (clr) begin
      wr_nx  = '0;
      rd_nx  = '0;
      cnt_nx = '0;
    end else begin
      if (do_push) wr_nx = bump(wr_q);
      if (do_pop)  rd_nx = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_nx = CW'(cnt_q + 1'b1);
        2'b01:   cnt_nx = CW'(cnt_q - 1'b1);
        default: cnt_nx = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_nx;
      rd_q  <= rd_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/icls_keycap.sv
module icls_keycap
  import icls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [1:0]         idx,
  input  logic [DW-1:0]      d,
  input  logic [CLS_W-1:0]   ptype,
  input  logic [LOC_W-1:0]   cfg_rack,
  input  logic [LOC_W-1:0]   cfg_port,
  input  logic [LOC_W-1:0]   cfg_ifc,
  output logic [DW-1:0]      key,
  output logic [CLS_W-1:0]   cls,
  output logic [DW-1:0]      hdr
);
  logic [DW-1:0]      key_q, key_nx;
  logic [CLS_W-1:0]   cls_q, cls_nx;
  logic [PROTO_W-1:0] pro_q, pro_nx;
  logic [LOC_W-1:0]   rk_q, rk_nx, pt_q, pt_nx, if_q, if_nx;

  always_comb begin
    key_nx = key_q;
    cls_nx = cls_q;
    pro_nx = pro_q;
    rk_nx  = rk_q;
    pt_nx  = pt_q;
    if_nx  = if_q;
    if (cap) begin
      case (idx)
        2'd0: begin
          cls_nx = ptype;
          pro_nx = ptype[1] ? d[79:72] : d[55:48];
          rk_nx  = cfg_rack;
          pt_nx  = cfg_port;
          if_nx  = cfg_ifc;
          key_nx = '0;
        end
        2'd1: begin
          if (cls_q[1]) key_nx[DW-1:64] = d[63:0];
          else          key_nx = {{(DW-32){1'b0}}, d[127:96]};
        end
        2'd2:    key_nx[63:0] = d[127:64];
        default: key_nx = key_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      cls_q <= '0;
      pro_q <= '0;
      rk_q  <= '0;
      pt_q  <= '0;
      if_q  <= '0;
    end else begin
      key_q <= key_nx;
      cls_q <= cls_nx;
      pro_q <= pro_nx;
      rk_q  <= rk_nx;
      pt_q  <= pt_nx;
      if_q  <= if_nx;
    end
  end

  assign key = key_q;
  assign cls = cls_q;
  assign hdr = build_hdr(cls_q, pro_q, rk_q, pt_q, if_q);
endmodule

// File: rtl/icls_timer.sv
module icls_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_nx;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_nx = run ? CW'(cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/ingress_classifier.sv
module ingress_classifier
  import icls_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int CNT_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LOC_W-1:0]     cfg_rack,
  input  logic [LOC_W-1:0]     cfg_port,
  input  logic [LOC_W-1:0]     cfg_ifc,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic [MTY_W-1:0]     in_mty,
  input  logic [CLS_W-1:0]     in_ptype,
  output logic                 lk_req_valid,
  output logic [DW-1:0]        lk_key,
  output logic [CLS_W-1:0]     lk_class,
  input  logic                 lk_resp_valid,
  input  logic                 lk_resp_hit,
  output logic                 host_valid,
  input  logic                 host_ready,
  output logic [DW-1:0]        host_data,
  output logic                 host_sop,
  output logic                 host_eop,
  output logic [MTY_W-1:0]     host_mty,
  output logic                 fab_valid,
  input  logic                 fab_ready,
  output logic [DW-1:0]        fab_data,
  output logic                 fab_sop,
  output logic                 fab_eop,
  output logic [MTY_W-1:0]     fab_mty,
  output logic [CNT_W-1:0]     drop_count
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  st_e              st_q, st_nx;
  logic [1:0]       idx_q, idx_nx;
  logic             done_q, done_nx;
  logic             tohost_q, tohost_nx;
  logic [CNT_W-1:0] drop_q, drop_nx;

  logic        acc, cap, fifo_clr, fifo_pop, f_empty, f_full;
  logic        tmo, drop_inc, sel_rdy, streaming;
  logic [1:0]  need_last;
  beat_t       f_in, f_out;
  logic [DW-1:0] hdr;

  assign f_in = '{data: in_data, sop: in_sop, eop: in_eop, mty: in_mty};

  icls_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (arst_n),
    .clr   (fifo_clr),
    .push  (acc),
    .din   (f_in),
    .pop   (fifo_pop),
    .dout  (f_out),
    .empty (f_empty),
    .full  (f_full)
  );

  icls_keycap u_keycap (
    .clk      (clk),
    .rst_n    (arst_n),
    .cap      (cap),
    .idx      (idx_q),
    .d        (in_data),
    .ptype    (in_ptype),
    .cfg_rack (cfg_rack),
    .cfg_port (cfg_port),
    .cfg_ifc  (cfg_ifc),
    .key      (lk_key),
    .cls      (lk_class),
    .hdr      (hdr)
  );

  icls_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (arst_n),
    .run     (st_q == ST_WAIT && !lk_resp_valid),
    .expired (tmo)
  );

  assign streaming = (st_q == ST_FWD) || (st_q == ST_DROP);

  always_comb begin
    case (st_q)
      ST_COLLECT:     in_ready = !f_full;
      ST_FWD, ST_DROP: in_ready = !done_q && !f_full;
      default:        in_ready = 1'b0;
    endcase
  end

  assign acc       = in_valid && in_ready;
  assign cap       = acc && (st_q == ST_COLLECT);
  assign need_last = ((idx_q == 2'd0) ? in_ptype[1] : lk_class[1]) ? 2'd2 : 2'd1;
  assign sel_rdy   = tohost_q ? host_ready : fab_ready;
  assign fifo_pop  = streaming && !f_empty && ((st_q == ST_DROP) || sel_rdy);

  // next state
  always_comb begin
    st_nx     = st_q;
    idx_nx    = idx_q;
    done_nx   = done_q;
    tohost_nx = tohost_q;
    fifo_clr  = 1'b0;
    drop_inc  = 1'b0;
    case (st_q)
      ST_COLLECT: begin
        if (acc) begin
          if (idx_q == need_last) begin
            st_nx   = ST_LOOKUP;
            done_nx = in_eop;
            idx_nx  = '0;
          end else if (in_eop) begin
            fifo_clr = 1'b1;
            drop_inc = 1'b1;
            idx_nx   = '0;
          end else begin
            idx_nx = 2'(idx_q + 1'b1);
          end
        end
      end
      ST_LOOKUP: st_nx = ST_WAIT;
      ST_WAIT: begin
        if (lk_resp_valid) begin
          tohost_nx = lk_resp_hit;
          st_nx     = lk_resp_hit ? ST_FWD : ST_HDR;
        end else if (tmo) begin
          st_nx    = ST_DROP;
          drop_inc = 1'b1;
        end
      end
      ST_HDR: begin
        if (fab_ready) st_nx = ST_FWD;
      end
      ST_FWD, ST_DROP: begin
        if (acc && in_eop) done_nx = 1'b1;
        if (fifo_pop && f_out.eop) begin
          st_nx   = ST_COLLECT;
          done_nx = 1'b0;
        end
      end
      default: st_nx = ST_COLLECT;
    endcase
    drop_nx = (drop_inc && drop_q != '1) ? CNT_W'(drop_q + 1'b1) : drop_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q     <= ST_COLLECT;
      idx_q    <= '0;
      done_q   <= 1'b0;
      tohost_q <= 1'b0;
      drop_q   <= '0;
    end else begin
      st_q     <= st_nx;
      idx_q    <= idx_nx;
      done_q   <= done_nx;
      tohost_q <= tohost_nx;
      drop_q   <= drop_nx;
    end
  end

  assign lk_req_valid = (st_q == ST_LOOKUP);
  assign drop_count   = drop_q;

  assign host_valid = (st_q == ST_FWD) && tohost_q && !f_empty;
  assign host_data  = f_out.data;
  assign host_sop   = f_out.sop;
  assign host_eop   = f_out.eop;
  assign host_mty   = f_out.mty;

  assign fab_valid = (st_q == ST_HDR) || ((st_q == ST_FWD) && !tohost_q && !f_empty);
  assign fab_data  = (st_q == ST_HDR) ? hdr : f_out.data;
  assign fab_sop   = (st_q == ST_HDR);
  assign fab_eop   = (st_q == ST_HDR) ? 1'b0 : f_out.eop;
  assign fab_mty   = (st_q == ST_HDR) ? '0 : f_out.mty;
endmodule

// File: rtl/icls_checker.sv
module icls_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             lk_req_valid,
  input logic             host_valid,
  input logic             host_ready,
  input logic [127:0]     host_data,
  input logic             host_eop,
  input logic             fab_valid,
  input logic             fab_ready,
  input logic [127:0]     fab_data,
  input logic             fab_sop,
  input logic             fab_eop,
  input logic [CNT_W-1:0] drop_count
);
  localparam logic [127:0] HDR_ZERO_MASK = {2'b11, 19'b0, {107{1'b1}}};

  assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_valid |=> !lk_req_valid);

  assert_input_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_valid |=> !in_ready);

  assert_single_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && fab_valid));

  assert_hdr_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && fab_sop) |-> ((fab_data & HDR_ZERO_MASK) == '0 && !fab_eop));

  assert_host_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_data) && $stable(host_eop)));

  assert_fab_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && !fab_ready) |=> (fab_valid && $stable(fab_data) && $stable(fab_sop)));

  assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == CNT_W'($past(drop_count) + 1'b1)));
endmodule

bind ingress_classifier icls_checker #(.CNT_W(CNT_W)) u_icls_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .lk_req_valid (lk_req_valid),
  .host_valid   (host_valid),
  .host_ready   (host_ready),
  .host_data    (host_data),
  .host_eop     (host_eop),
  .fab_valid    (fab_valid),
  .fab_ready    (fab_ready),
  .fab_data     (fab_data),
  .fab_sop      (fab_sop),
  .fab_eop      (fab_eop),
  .drop_count   (drop_count)
);

// File: tb/test_ingress_classifier.sv
module test_ingress_classifier;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cfg_rack = '0, cfg_port = '0, cfg_ifc = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_sop = 1'b0, in_eop = 1'b0;
  logic [3:0]   in_mty = '0;
  logic [1:0]   in_ptype = '0;
  logic         lk_req_valid;
  logic [127:0] lk_key;
  logic [1:0]   lk_class;
  logic         lk_resp_valid = 1'b0, lk_resp_hit = 1'b0;
  logic         host_valid, host_ready = 1'b1;
  logic [127:0] host_data;
  logic         host_sop, host_eop;
  logic [3:0]   host_mty;
  logic         fab_valid, fab_ready = 1'b1;
  logic [127:0] fab_data;
  logic         fab_sop, fab_eop;
  logic [3:0]   fab_mty;
  logic [15:0]  drop_count;

  ingress_classifier i_ingress_classifier (
    .clk(clk), .rst_n(rst_n),
    .cfg_rack(cfg_rack), .cfg_port(cfg_port), .cfg_ifc(cfg_ifc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_mty(in_mty), .in_ptype(in_ptype),
    .lk_req_valid(lk_req_valid), .lk_key(lk_key), .lk_class(lk_class),
    .lk_resp_valid(lk_resp_valid), .lk_resp_hit(lk_resp_hit),
    .host_valid(host_valid), .host_ready(host_ready), .host_data(host_data),
    .host_sop(host_sop), .host_eop(host_eop), .host_mty(host_mty),
    .fab_valid(fab_valid), .fab_ready(fab_ready), .fab_data(fab_data),
    .fab_sop(fab_sop), .fab_eop(fab_eop), .fab_mty(fab_mty),
    .drop_count(drop_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [134:0] host_q[$];
  logic [134:0] fab_q[$];
  logic [129:0] lk_q[$];
  int  n_chk = 0, n_bad = 0, exp_drops = 0, pkt_no = 0;
  bit  resp_silent = 1'b0, bp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_local(input logic [1:0] c, input logic [127:0] k);
    case (c)
      2'b00:   return k == {96'b0, 32'h0A01_0203};
      2'b01:   return k == {96'b0, 32'hE000_0005};
      2'b10:   return k == 128'h2001_0DB8_0000_0000_0000_0000_0000_0001;
      default: return k == 128'hFF02_0000_0000_0000_0000_0000_0000_0002;
    endcase
  endfunction

  task automatic send_pkt(input logic [1:0] c, input logic [127:0] a, input logic [7:0] pr,
                          input int nb, input logic [3:0] mt,
                          input logic [2:0] rk, input logic [2:0] pt, input logic [2:0] ifn);
    logic [127:0] bt [8];
    logic [127:0] key;
    int need;
    need = c[1] ? 3 : 2;
    key  = c[1] ? a : {96'b0, a[31:0]};
    for (int i = 0; i < 8; i++) bt[i] = {4{32'(32'h5EED_0000 + pkt_no * 16 + i)}};
    pkt_no++;
    if (c[1]) bt[0][79:72] = pr; else bt[0][55:48] = pr;
    if (nb > 1) begin
      if (c[1]) bt[1][63:0] = a[127:64]; else bt[1][127:96] = a[31:0];
    end
    if (nb > 2 && c[1]) bt[2][127:64] = a[63:0];
    if (nb < need) begin
      exp_drops++;
    end else begin
      lk_q.push_back({c, key});
      if (resp_silent) exp_drops++;
      else if (is_local(c, key)) begin
        for (int i = 0; i < nb; i++)
          host_q.push_back({1'b0, bt[i], i == 0, i == nb - 1, (i == nb - 1) ? mt : 4'd0});
      end else begin
        fab_q.push_back({1'b1, 2'b00, c, pr, rk, pt, ifn, 107'b0, 1'b1, 1'b0, 4'd0});
        for (int i = 0; i < nb; i++)
          fab_q.push_back({1'b0, bt[i], 1'b0, i == nb - 1, (i == nb - 1) ? mt : 4'd0});
      end
    end
    cfg_rack = rk; cfg_port = pt; cfg_ifc = ifn;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      if (i == 1) begin cfg_rack = ~rk; cfg_port = ~pt; cfg_ifc = ~ifn; end
      in_valid = 1'b1; in_data = bt[i]; in_ptype = c;
      in_sop = (i == 0); in_eop = (i == nb - 1); in_mty = (i == nb - 1) ? mt : 4'd0;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (host_q.size() == 0 && fab_q.size() == 0 && lk_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  // output ready pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    host_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
    fab_ready  = bp_on ? ($urandom % 3 != 0) : 1'b1;
  end

  // address-match engine model
  always begin
    logic [127:0] k;
    logic [1:0]   c;
    @(negedge clk);
    if (rst_n && lk_req_valid && !resp_silent) begin
      k = lk_key; c = lk_class;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!in_ready, "R6 input must stay closed during lookup", 128'(in_ready), 128'd0);
      end
      lk_resp_hit   = is_local(c, k);
      lk_resp_valid = 1'b1;
      @(negedge clk);
      lk_resp_valid = 1'b0;
    end
  end

  // monitor / scoreboard
  logic         h_stall = 1'b0, f_stall = 1'b0;
  logic [127:0] h_prev, f_prev;
  always @(negedge clk) begin
    logic [134:0] it;
    logic [129:0] lr;
    if (rst_n) begin
      if (h_stall) chk(host_valid && host_data == h_prev, "R9 host beat held", host_data, h_prev);
      if (f_stall) chk(fab_valid && fab_data == f_prev, "R9 fabric beat held", fab_data, f_prev);
      h_stall = host_valid && !host_ready; h_prev = host_data;
      f_stall = fab_valid && !fab_ready;   f_prev = fab_data;
      if (lk_req_valid) begin
        if (lk_q.size() == 0) chk(1'b0, "R1 unexpected lookup (R8)", lk_key, 128'd0);
        else begin
          lr = lk_q.pop_front();
          chk({lk_class, lk_key} == lr, "R1 lookup key/class", lk_key, lr[127:0]);
        end
      end
      if (host_valid && host_ready) begin
        if (host_q.size() == 0) chk(1'b0, "R2 unexpected host beat", host_data, 128'd0);
        else begin
          it = host_q.pop_front();
          chk({host_data, host_sop, host_eop, host_mty} == it[133:0], "R2 host beat", host_data, it[133:6]);
        end
      end
      if (fab_valid && fab_ready) begin
        if (fab_q.size() == 0) chk(1'b0, "R3 unexpected fabric beat", fab_data, 128'd0);
        else begin
          it = fab_q.pop_front();
          chk({fab_data, fab_sop, fab_eop, fab_mty} == it[133:0],
              it[134] ? "R3 R4 R5 header beat" : "R3 fabric packet beat", fab_data, it[133:6]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!host_valid && !fab_valid, "R10 outputs idle in reset", {host_valid, fab_valid}, 0);
    chk(!lk_req_valid, "R10 no lookup in reset", 128'(lk_req_valid), 0);
    chk(drop_count == 0, "R10 drop count zero", 128'(drop_count), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 hit, R3 miss for each class, minimum lengths exactly at address end
    send_pkt(2'b00, 128'h0A01_0203, 8'h06, 3, 4'd8, 3'd1, 3'd2, 3'd3);
    send_pkt(2'b00, 128'h0A01_0209, 8'h11, 2, 4'd3, 3'd7, 3'd0, 3'd5);
    send_pkt(2'b01, 128'hE000_0005, 8'h02, 4, 4'd0, 3'd4, 3'd4, 3'd4);
    send_pkt(2'b01, 128'hE000_0077, 8'h59, 3, 4'd1, 3'd6, 3'd5, 3'd0);
    send_pkt(2'b10, 128'h2001_0DB8_0000_0000_0000_0000_0000_0001, 8'h3A, 5, 4'd2, 3'd2, 3'd6, 3'd1);
    send_pkt(2'b10, 128'h2001_0DB8_0000_0000_0000_0000_0000_0044, 8'h06, 3, 4'd0, 3'd5, 3'd1, 3'd7);
    send_pkt(2'b11, 128'hFF02_0000_0000_0000_0000_0000_0000_0002, 8'h11, 3, 4'd7, 3'd0, 3'd7, 3'd2);
    send_pkt(2'b11, 128'hFF05_0000_0000_0000_0000_0000_0000_0009, 8'h67, 6, 4'd5, 3'd3, 3'd3, 3'd6);
    wait_idle();

    // R8 truncated packets
    send_pkt(2'b00, 128'h0A01_0203, 8'h06, 1, 4'd0, 3'd1, 3'd1, 3'd1);
    send_pkt(2'b10, 128'h2001_0DB8_0000_0000_0000_0000_0000_0001, 8'h06, 2, 4'd4, 3'd1, 3'd1, 3'd1);
    wait_idle();
    chk(drop_count == 16'(exp_drops), "R8 truncated packets counted", 128'(drop_count), 128'(exp_drops));

    // R7 timeout, then recovery
    resp_silent = 1'b1;
    send_pkt(2'b00, 128'h0A01_0203, 8'h06, 4, 4'd0, 3'd2, 3'd2, 3'd2);
    resp_silent = 1'b0;
    wait_idle();
    chk(drop_count == 16'(exp_drops), "R7 timeout counted", 128'(drop_count), 128'(exp_drops));
    send_pkt(2'b00, 128'h0A01_0203, 8'h01, 3, 4'd6, 3'd3, 3'd4, 3'd5);
    send_pkt(2'b01, 128'hE000_1234, 8'h02, 3, 4'd0, 3'd6, 3'd1, 3'd2);
    wait_idle();

    // R9 backpressure on both outputs with mixed traffic
    bp_on = 1'b1;
    for (int n = 0; n < 12; n++) begin
      send_pkt(2'(n), (n % 3 == 0) ? ((n % 4 < 2) ? ((n % 4 == 0) ? 128'h0A01_0203 : 128'hE000_0005)
                                       : ((n % 4 == 2) ? 128'h2001_0DB8_0000_0000_0000_0000_0000_0001
                                                       : 128'hFF02_0000_0000_0000_0000_0000_0000_0002))
                                   : {32'(n), 96'h1357_9BDF_0246_8ACE_1111_2222},
               8'(n * 7), 3 + (n % 4), 4'(n), 3'(n), 3'(n + 1), 3'(n + 2));
    end
    wait_idle();
    bp_on = 1'b0;
    wait_idle();

    chk(host_q.size() == 0 && fab_q.size() == 0, "R2 R3 all expected beats delivered",
        128'(host_q.size() + fab_q.size()), 128'd0);
    chk(lk_q.size() == 0, "R1 all expected lookups seen", 128'(lk_q.size()), 128'd0);
    chk(drop_count == 16'(exp_drops), "R7 final drop count", 128'(drop_count), 128'(exp_drops));
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule